// File: doc/BRIEF.md
# Latched Serial-In Parallel-Out Register

This block takes a serial bit stream into a shift register on the rising edge of a shift clock. On the rising edge of a second, independent storage clock it copies the whole shift register into a storage register. The storage register drives the parallel outputs. The last shift stage is also brought out as a serial output, so several copies can be chained: each copy's serial output feeds the next copy's serial input, and all copies share both clocks. The result behaves as one long register whose parallel image is updated in a single step.

Only the shift register has a reset, which is asynchronous and active low. The storage register is never reset and starts from all zeros at power-on. The parallel outputs can be released to a high-impedance condition by an active-low output enable. On chip this condition is modelled as one enable flag per output line, for use as a pad enable, rather than as an internal tri-state net. The serial output is always driven.

If both clocks come from one net, the storage register captures the shift contents as they stood before that edge. The parallel image then trails the shift register by one shift.

Top module: `latched_sipo`

## Requirements
- R1: On each rising edge of `shift_clk` with `rst_n` high, `ser_in` enters shift bit 0 and each shift bit i moves to bit i+1.
- R2: On each rising edge of `store_clk`, all WIDTH shift bits are copied at once into the storage register, which appears on `q`. `q[i]` equals shift bit i.
- R3: While `rst_n` is low, the shift register is cleared at once without any clock edge, so `ser_out` reads 0. The storage register, and therefore `q`, is left unchanged.
- R4: When `oe_n` is 0, every bit of `q_oe` is 1. When `oe_n` is 1, every bit of `q_oe` is 0. `oe_n` never alters the value on `q` or the storage contents.
- R5: `ser_out` always equals shift bit WIDTH-1, whatever the value of `oe_n`.
- R6: Without a rising edge on either clock, `q` and `ser_out` hold their values, even if `ser_in` changes.
- R7: When `shift_clk` and `store_clk` rise together, the storage register takes the shift contents from before that edge.
- R8: At power-on, before any `store_clk` edge, `q` reads all zeros.
- R9: With two copies chained (`ser_out` of the first into `ser_in` of the second), after 8 further shifts the second copy holds the byte that the first copy held before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; shifts on its rising edge |
| store_clk | input | 1 | Storage clock; copies shift bits on its rising edge |
| rst_n | input | 1 | Active-low asynchronous clear of the shift register only |
| ser_in | input | 1 | Serial data input to shift bit 0 |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| q | output | WIDTH | Storage register contents |
| q_oe | output | WIDTH | Per-line drive enable; 0 means the line is high impedance |
| ser_out | output | 1 | Last shift bit, for chaining |

## Verification
On every edge of their own clock, the assertions check three things. Each shift moves `ser_in` and the lower bits up by one place. Each storage edge copies the pre-edge shift bits. `ser_out` follows the bit that was one position below it. Outside reset, the enable flags are checked to be all on or all off at all times. The bench scenarios are needed for the rest. These are the power-on zero of the storage register, the asynchronous clear that leaves `q` untouched, and the one-shift lag under a shared clock. The bench also sweeps all 256 byte patterns through a two-copy chain, which shows how data passes between the copies.

// File: rtl/latched_sipo_pkg.sv
// Package: shared constants and types for the latched serial-in
// parallel-out register.
package latched_sipo_pkg;

    localparam int unsigned SIPO_WIDTH = 8;

    // Drive state of the parallel output lines.
    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drive_e;

endpackage

// File: rtl/sipo_shift_stage.sv
// Shift stage: a WIDTH-bit shift register clocked by shift_clk.
// Bit 0 takes the serial input and bit WIDTH-1 is the oldest bit.
// Assumes WIDTH >= 2. The reset is asynchronous and active low because
// the clear must act without a shift clock.
module sipo_shift_stage #(
    parameter int unsigned WIDTH = latched_sipo_pkg::SIPO_WIDTH
) (
    input  logic             shift_clk,
    input  logic             rst_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] bits
);

    localparam int unsigned TOP = WIDTH - 1;

    // Shift the serial input in at bit 0; clear at once while rst_n is low.
    always_ff @(posedge shift_clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            bits <= {bits[TOP-1:0], ser_in};
        end
    end

    // R1: each shift places the sampled input at bit 0 and moves the others up.
    p_shift_in_r1: assert property (@(posedge shift_clk) disable iff (!rst_n)
        1'b1 |=> (bits == {$past(bits[TOP-1:0]), $past(ser_in)}))
        else $error("p_shift_in_r1");

endmodule

// File: rtl/sipo_store_stage.sv
// Storage stage: a WIDTH-bit register loaded from the shift stage on
// store_clk. It has no reset. Its power-on value of zero is given by a
// declaration initial value. rst_n is used only to qualify the checks.
module sipo_store_stage #(
    parameter int unsigned WIDTH = latched_sipo_pkg::SIPO_WIDTH
) (
    input  logic             store_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] held
);

    logic [WIDTH-1:0] held_r = '0;

    // Copy all shift bits at once on the storage clock edge.
    always_ff @(posedge store_clk) begin
        held_r <= d;
    end

    assign held = held_r;

    // R2: the value held after a storage edge is the shift image before that edge.
    p_capture_r2: assert property (@(posedge store_clk) disable iff (!rst_n)
        1'b1 |=> (held_r == $past(d)))
        else $error("p_capture_r2");

endmodule

// File: rtl/sipo_drive_stage.sv
// Drive stage: presents the storage contents on the parallel lines.
// Each line also gets its own enable flag in place of a tri-state net.
// Assumes the pad logic treats an enable of 0 as high impedance.
module sipo_drive_stage
    import latched_sipo_pkg::*;
#(
    parameter int unsigned WIDTH = SIPO_WIDTH
) (
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_oe
);

    drive_e drive;

    // Decode the active-low enable into the drive state.
    always_comb begin
        drive = oe_n ? DRV_OFF : DRV_ON;
    end

    // One data line and one enable flag for each output bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        assign q[i]    = held[i];
        assign q_oe[i] = (drive == DRV_ON);
    end

    // R4: all enable flags switch together, never a partial set.
    always_comb begin
        if (rst_n && !$isunknown(oe_n)) begin
            p_oe_uniform_r4: assert ((q_oe == '0) || (q_oe == '1))
                else $error("p_oe_uniform_r4");
        end
    end

endmodule

// File: rtl/latched_sipo.sv
// Top: latched serial-in parallel-out register with a chaining output.
// Two independent clocks are used. The shift register and the storage
// register only exchange data on the storage clock edge. The user keeps
// the storage edge after the last shift edge that should be captured.
module latched_sipo
    import latched_sipo_pkg::*;
#(
    parameter int unsigned WIDTH = SIPO_WIDTH
) (
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             oe_n,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_oe,
    output logic             ser_out
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] shift_bits;
    logic [WIDTH-1:0] store_bits;

    sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .shift_clk (shift_clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .bits      (shift_bits)
    );

    sipo_store_stage #(.WIDTH(WIDTH)) u_store (
        .store_clk (store_clk),
        .rst_n     (rst_n),
        .d         (shift_bits),
        .held      (store_bits)
    );

    sipo_drive_stage #(.WIDTH(WIDTH)) u_drive (
        .rst_n (rst_n),
        .oe_n  (oe_n),
        .held  (store_bits),
        .q     (q),
        .q_oe  (q_oe)
    );

    // The serial chaining output is the oldest shift bit and is always driven.
    assign ser_out = shift_bits[TOP];

    // R5: after each shift the serial output shows the bit that was one place below it.
    p_serial_out_r5: assert property (@(posedge shift_clk) disable iff (!rst_n)
        1'b1 |=> (ser_out == $past(shift_bits[TOP-1])))
        else $error("p_serial_out_r5");

endmodule

// File: tb/latched_sipo_bench.sv
// Bench: two chained copies of the register, driven by tasks.
// A 16-bit model of the chain computes every expected value.
module latched_sipo_bench;

    localparam int unsigned W = 8;

    logic clk = 1'b0;
    logic shift_clk = 1'b0;
    logic store_clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic oe_n = 1'b0;
    logic [W-1:0] q_a, q_b, oe_a, oe_b;
    logic so_a, so_b;

    int checks = 0;
    int errors = 0;

    // Model state: chain[7:0] is the first copy's shift register and
    // chain[15:8] is the second copy's.
    logic [2*W-1:0] chain = '0;
    logic [W-1:0] st_a = '0;
    logic [W-1:0] st_b = '0;

    always #10 clk = ~clk;

    latched_sipo #(.WIDTH(W)) u_latched_sipo (
        .shift_clk (shift_clk), .store_clk (store_clk), .rst_n (rst_n),
        .ser_in (ser_in), .oe_n (oe_n), .q (q_a), .q_oe (oe_a), .ser_out (so_a)
    );

    latched_sipo #(.WIDTH(W)) u_latched_sipo_b (
        .shift_clk (shift_clk), .store_clk (store_clk), .rst_n (rst_n),
        .ser_in (so_a), .oe_n (oe_n), .q (q_b), .q_oe (oe_b), .ser_out (so_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        ser_in = b;
        #5 shift_clk = 1'b1;
        chain = {chain[2*W-2:0], b};
        #10 shift_clk = 1'b0;
        #5;
    endtask

    task automatic store_pulse();
        #5 store_clk = 1'b1;
        st_a = chain[W-1:0];
        st_b = chain[2*W-1:W];
        #10 store_clk = 1'b0;
        #5;
    endtask

    task automatic both_pulse(input logic b);
        ser_in = b;
        #5 shift_clk = 1'b1; store_clk = 1'b1;
        st_a = chain[W-1:0];
        st_b = chain[2*W-1:W];
        chain = {chain[2*W-2:0], b};
        #10 shift_clk = 1'b0; store_clk = 1'b0;
        #5;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] prev;
        #25;
        chk("R8 power-on q_a", q_a, 0);
        chk("R8 power-on q_b", q_b, 0);
        chk("R3 serial out in reset", so_a, 0);
        chk("R4 enable on", oe_a, 8'hFF);
        rst_n = 1'b1;
        #20;

        // R1 R2 R9: sweep every byte through the chain.
        prev = '0;
        for (int p = 0; p < 256; p++) begin
            for (int k = W - 1; k >= 0; k--) shift_bit(p[k]);
            store_pulse();
            chk("R1 R2 q_a byte", q_a, p[W-1:0]);
            chk("R9 q_b previous byte", q_b, prev);
            chk("R9 q_b model", q_b, st_b);
            chk("R5 ser_out chain end", so_b, chain[2*W-1]);
            prev = p[W-1:0];
        end

        // R1: a single shift moves the stored image only after a store.
        shift_bit(1'b1);
        chk("R2 q holds before store", q_a, st_a);
        store_pulse();
        chk("R1 one shift", q_a, chain[W-1:0]);

        // R6: input changes without clock edges have no effect.
        ser_in = ~ser_in;
        #20;
        ser_in = ~ser_in;
        #20;
        chk("R6 q_a hold", q_a, st_a);
        chk("R6 ser_out hold", so_a, chain[W-1]);

        // R4 R5: output enable gates only the enable flags.
        oe_n = 1'b1;
        #10;
        chk("R4 enable off a", oe_a, 0);
        chk("R4 enable off b", oe_b, 0);
        chk("R4 q unchanged when off", q_a, st_a);
        shift_bit(1'b0);
        shift_bit(1'b1);
        chk("R5 ser_out while disabled", so_a, chain[W-1]);
        store_pulse();
        chk("R4 store while disabled", q_a, chain[W-1:0]);
        oe_n = 1'b0;
        #10;
        chk("R4 enable back on", oe_a, 8'hFF);
        chk("R4 q after re-enable", q_a, st_a);

        // R7: a shared clock captures the pre-edge shift image.
        for (int k = 0; k < W; k++) shift_bit(k[0]);
        both_pulse(1'b1);
        chk("R7 q_a lags by one", q_a, st_a);
        chk("R7 shift moved on", so_a, chain[W-1]);
        store_pulse();
        chk("R7 catch-up", q_a, chain[W-1:0]);

        // R3: asynchronous clear of the shift register only.
        for (int k = 0; k < W; k++) shift_bit(1'b1);
        store_pulse();
        rst_n = 1'b0;
        chain = '0;
        #5;
        chk("R3 shift cleared", so_a, 0);
        chk("R3 q kept", q_a, 8'hFF);
        chk("R3 q_b kept", q_b, st_b);
        #10 rst_n = 1'b1;
        #10;
        store_pulse();
        chk("R3 cleared image stored", q_a, 0);

        finish_run();
    end

endmodule